// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block holds the event flags, the per-source enables and the interrupt request outputs for one 16-bit timer/counter. It watches the running count, three compare values, an overflow pulse and an external capture event, and turns each into a sticky flag bit. The counter, waveform logic and output pins sit elsewhere. The block only decides when a flag is raised, how it is cleared and when a request reaches the interrupt controller.

Software sees two 8-bit registers through a small bus port. The flag register is at address 0. A written 1 clears a flag, and a written 0 leaves it alone. The enable register is at address 1 and is plainly readable and writable. Hardware also clears a flag when the interrupt controller acknowledges that source's vector. A mode input lets the capture flag follow the count reaching the top value held in the capture register, in place of the capture pin.

Top module: `tmr_irq_flags`

## Requirements
- R1: Bit positions of both registers: bit 0 overflow, bit 1 compare A, bit 2 compare B, bit 3 compare C, bit 5 capture. Bits 7, 6 and 4 of both registers always read 0, and writes to them have no effect.
- R2: After reset every flag, every enable bit and every request output is 0.
- R3: Take a cycle in which `tick_en`=1, `cnt_val` equals a channel's compare value and that channel's force strobe is 0. That channel's flag reads 1 after the second rising edge that follows the cycle, not after the first.
- R4: A count that equals a compare value while `tick_en`=0 does not set the compare flag.
- R5: A force strobe never sets a compare flag. A match in the same cycle as that channel's strobe does not set the flag either.
- R6: With `top_is_cap`=0, a `cap_event` pulse sets the capture flag (bit 5) on the next edge, and a count equal to `cap_reg` does not set it.
- R7: With `top_is_cap`=1, the capture flag is set on the next edge after a cycle with `tick_en`=1 and `cnt_val`==`cap_reg`, and `cap_event` does not set it.
- R8: An `ovf_pulse` sets the overflow flag (bit 0) on the next edge.
- R9: `irq_ack[i]` clears the flag of source i on the next edge. The source order is 0 overflow, 1 A, 2 B, 3 C, 4 capture.
- R10: A bus write to address 0 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0.
- R11: When a set event and a clear (acknowledge or written 1) hit the same flag in the same cycle, the flag ends up set.
- R12: A bus write to address 1 stores the enable bits. Reading address 1 returns them, and reading address 0 returns the flags.
- R13: `irq[i]` is 1 exactly when source i has its flag set, its enable bit set and `gie`=1. The source order is the one given in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable, 1 in cycles where the timer advances |
| cnt_val | input | 16 | Running counter value |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| cmp_c | input | 16 | Compare value, channel C |
| cap_reg | input | 16 | Capture register, which is also the top value when `top_is_cap`=1 |
| top_is_cap | input | 1 | Mode bit: capture register serves as top |
| ovf_pulse | input | 1 | Counter overflow event |
| cap_event | input | 1 | External capture event |
| force_cmp | input | 3 | Forced-compare strobes for C, B, A (bit 2..0) |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 8 | Bus write data |
| reg_rdata | output | 8 | Bus read data for `reg_addr` |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 5 | Per-source vector acknowledge |
| irq | output | 5 | Per-source interrupt request |

## Verification
Two actions can meet on one flag in the same cycle: a hardware set and a clear, where the clear is either an acknowledge or a written 1. The bench forces the meeting in directed steps. It pulses overflow together with its acknowledge and a clearing write, and it lines up a delayed compare hit with the clearing write on that bit. The random phase draws counts and compare values from a tiny range, so such collisions keep recurring. Every cycle the bench model predicts the read data and the requests, with set taking priority, and the design's outputs must match that prediction.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int NSRC    = 5;
  localparam int NCMP    = 3;
  localparam int SRC_OVF = 0;
  localparam int SRC_CMA = 1;
  localparam int SRC_CMB = 2;
  localparam int SRC_CMC = 3;
  localparam int SRC_CAP = 4;

  // Byte position of each source's flag/enable bit.
  function automatic int unsigned src_bit(input int unsigned s);
    return (s == SRC_CAP) ? 5 : s;
  endfunction

  // Bits of the byte that carry state.
  function automatic logic [7:0] valid_bits();
    logic [7:0] v;
    v = '0;
    for (int s = 0; s < NSRC; s++) v[src_bit(s)] = 1'b1;
    return v;
  endfunction

  // Scatter per-source vector into byte positions.
  function automatic logic [7:0] to_byte(input logic [NSRC-1:0] v);
    logic [7:0] b;
    b = '0;
    for (int s = 0; s < NSRC; s++) b[src_bit(s)] = v[s];
    return b;
  endfunction

  // Gather byte positions into per-source vector.
  function automatic logic [NSRC-1:0] from_byte(input logic [7:0] b);
    logic [NSRC-1:0] v;
    for (int s = 0; s < NSRC; s++) v[s] = b[src_bit(s)];
    return v;
  endfunction
endpackage

// File: rtl/tif_cmp_detect.sv
module tif_cmp_detect #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [CW-1:0]       cnt_val,
  input  logic [NCH*CW-1:0]   cmp_flat,
  input  logic [NCH-1:0]      force_cmp,
  output logic [NCH-1:0]      hit_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic eq;
    assign eq = tick_en && (cnt_val == cmp_flat[g*CW +: CW]) && !force_cmp[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q[g] <= 1'b0;
      else        hit_q[g] <= eq;
    end
  end
endmodule

// File: rtl/tif_cap_sel.sv
module tif_cap_sel #(
  parameter int CW = 16
) (
  input  logic          top_is_cap,
  input  logic          tick_en,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cap_reg,
  input  logic          cap_event,
  output logic          cap_set
);
  logic at_top;
  assign at_top  = tick_en && (cnt_val == cap_reg);
  assign cap_set = top_is_cap ? at_top : cap_event;
endmodule

// File: rtl/tif_flag_reg.sv
module tif_flag_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_vec
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_vec[g] <= 1'b0;
      else if (set_vec[g]) flag_vec[g] <= 1'b1;
      else if (clr_vec[g]) flag_vec[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [CW-1:0] cmp_c,
  input  logic [CW-1:0] cap_reg,
  input  logic          top_is_cap,
  input  logic          ovf_pulse,
  input  logic          cap_event,
  input  logic [2:0]    force_cmp,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          gie,
  input  logic [4:0]    irq_ack,
  output logic [4:0]    irq
);
  localparam logic [7:0] VALID = valid_bits();

  logic [NCMP-1:0] cmp_hit;
  logic            cap_set;
  logic [NSRC-1:0] set_vec, clr_vec, w1c_vec, flag_vec, en_vec;
  logic [7:0]      flag_byte, en_byte;
  logic            wr_flags, wr_en;

  assign wr_flags = reg_wr && (reg_addr == 1'b0);
  assign wr_en    = reg_wr && (reg_addr == 1'b1);

  tif_cmp_detect #(.CW(CW), .NCH(NCMP)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_val  (cnt_val),
    .cmp_flat ({cmp_c, cmp_b, cmp_a}),
    .force_cmp(force_cmp),
    .hit_q    (cmp_hit)
  );

  tif_cap_sel #(.CW(CW)) u_cap (
    .top_is_cap(top_is_cap),
    .tick_en   (tick_en),
    .cnt_val   (cnt_val),
    .cap_reg   (cap_reg),
    .cap_event (cap_event),
    .cap_set   (cap_set)
  );

  assign set_vec = {cap_set, cmp_hit, ovf_pulse};
  assign w1c_vec = wr_flags ? from_byte(reg_wdata) : '0;
  assign clr_vec = irq_ack | w1c_vec;

  tif_flag_reg #(.N(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flag_vec(flag_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_vec <= '0;
    else if (wr_en) en_vec <= from_byte(reg_wdata);
  end

  assign flag_byte = to_byte(flag_vec) & VALID;
  assign en_byte   = to_byte(en_vec) & VALID;
  assign reg_rdata = reg_addr ? en_byte : flag_byte;
  assign irq       = gie ? (flag_vec & en_vec) : '0;
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       ovf_pulse,
  input logic [2:0] force_cmp,
  input logic       gie,
  input logic [4:0] irq_ack,
  input logic [4:0] irq,
  input logic [2:0] cmp_hit,
  input logic [4:0] set_vec,
  input logic [4:0] flag_vec,
  input logic [7:0] flag_byte,
  input logic [7:0] en_byte
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_byte | en_byte) & 8'hD0) == 8'h00); // R1
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> cmp_hit == 3'b000); // R4
  AST_FORCE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp != 3'b000) |=> (cmp_hit & $past(force_cmp)) == 3'b000); // R5
  AST_CMP_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit[0] |=> flag_byte[1]); // R3
  AST_CMP_C_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit[2] |=> flag_byte[3]); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> flag_byte[0]); // R8
  AST_NO_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq == 5'b00000); // R13
  for (genvar i = 0; i < 5; i++) begin : g_src
    AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[i] && !set_vec[i]) |=> !flag_vec[i]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_vec[i]); // R11
  end
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .ovf_pulse(ovf_pulse),
  .force_cmp(force_cmp),
  .gie      (gie),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .cmp_hit  (cmp_hit),
  .set_vec  (set_vec),
  .flag_vec (flag_vec),
  .flag_byte(flag_byte),
  .en_byte  (en_byte)
);

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] cnt_val = '0, cmp_a = '0, cmp_b = '0, cmp_c = '0, cap_reg = '0;
  logic        top_is_cap = 1'b0, ovf_pulse = 1'b0, cap_event = 1'b0;
  logic [2:0]  force_cmp = '0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        gie = 1'b0;
  logic [4:0]  irq_ack = '0;
  logic [4:0]  irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R2";

  // bench model, source order: ovf, A, B, C, capture
  logic [4:0] m_flag = '0, m_en = '0;
  logic [2:0] m_pend = '0;

  always #2 clk = ~clk;

  tmr_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cap_reg(cap_reg),
    .top_is_cap(top_is_cap), .ovf_pulse(ovf_pulse), .cap_event(cap_event),
    .force_cmp(force_cmp), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie),
    .irq_ack(irq_ack), .irq(irq)
  );

  function automatic logic [7:0] pack_byte(input logic [4:0] v);
    return {2'b00, v[4], 1'b0, v[3:0]};
  endfunction

  function automatic logic [4:0] unpack_byte(input logic [7:0] b);
    return {b[5], b[3:0]};
  endfunction

  task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", cur_req, what, act, exp);
    end
  endtask

  // Called just after a negedge with inputs in place.
  task automatic step();
    logic [4:0] setv, clrv;
    logic [2:0] eqv;
    #1;
    check8("rdata", reg_rdata, reg_addr ? pack_byte(m_en) : pack_byte(m_flag));
    check8("irq", {3'b000, irq}, {3'b000, gie ? (m_flag & m_en) : 5'b0});
    @(posedge clk);
    eqv[0] = tick_en && cnt_val == cmp_a && !force_cmp[0];
    eqv[1] = tick_en && cnt_val == cmp_b && !force_cmp[1];
    eqv[2] = tick_en && cnt_val == cmp_c && !force_cmp[2];
    setv = {top_is_cap ? (tick_en && cnt_val == cap_reg) : cap_event, m_pend, ovf_pulse};
    clrv = irq_ack | ((reg_wr && !reg_addr) ? unpack_byte(reg_wdata) : 5'b0);
    m_flag = setv | (m_flag & ~clrv);
    m_pend = eqv;
    if (reg_wr && reg_addr) m_en = unpack_byte(reg_wdata);
    @(negedge clk);
    ovf_pulse = 0; cap_event = 0; force_cmp = '0; irq_ack = '0; reg_wr = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R2"; step();
    reg_addr = 1; step();
    rst_n = 1; @(negedge clk);
    cmp_a = 16'h0010; cmp_b = 16'h0020; cmp_c = 16'h0030; cap_reg = 16'h0040;
    cnt_val = 16'h0100;
    reg_addr = 1; step();

    cur_req = "R12"; wr(1, 8'h2F); step(); reg_addr = 1; step();
    cur_req = "R1"; wr(1, 8'hFF); step(); reg_addr = 1; step();
    wr(0, 8'hD0); step(); reg_addr = 0; step();

    cur_req = "R8"; ovf_pulse = 1; step(); step();
    cur_req = "R10"; wr(0, 8'h00); step(); step();
    wr(0, 8'h01); step(); step();

    cur_req = "R3"; tick_en = 1; cnt_val = cmp_a; step();
    cnt_val = 16'h0100; step(); step(); step();
    cur_req = "R4"; tick_en = 0; cnt_val = cmp_b; step(); step(); step();
    cur_req = "R5"; tick_en = 1; cnt_val = cmp_c; force_cmp = 3'b100; step();
    cnt_val = 16'h0100; force_cmp = 3'b111; step(); step(); step();

    cur_req = "R6"; top_is_cap = 0; cnt_val = cap_reg; step(); step();
    cnt_val = 16'h0100; cap_event = 1; step(); step();
    cur_req = "R9"; irq_ack = 5'b11111; step(); step();
    cur_req = "R7"; top_is_cap = 1; cap_event = 1; step(); step();
    cnt_val = cap_reg; step(); cnt_val = 16'h0100; step(); step();

    cur_req = "R11"; ovf_pulse = 1; irq_ack = 5'b00001; wr(0, 8'h01); step(); step();
    cnt_val = cmp_b; step(); cnt_val = 16'h0100; irq_ack = 5'b00100; wr(0, 8'h04); step(); step();

    cur_req = "R13"; gie = 0; step(); gie = 1; step();
    wr(1, 8'h05); step(); step(); wr(1, 8'h00); step(); gie = 0; step();

    cur_req = "RND";
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      tick_en    = ($urandom % 4) != 0;
      cnt_val    = 16'($urandom % 4);
      cmp_a      = 16'($urandom % 4);
      cmp_b      = 16'($urandom % 4);
      cmp_c      = 16'($urandom % 4);
      cap_reg    = 16'($urandom % 4);
      top_is_cap = ($urandom % 3) == 0;
      ovf_pulse  = ($urandom % 5) == 0;
      cap_event  = ($urandom % 5) == 0;
      force_cmp  = 3'(($urandom % 4 == 0) ? $urandom : 0);
      irq_ack    = 5'(($urandom % 3 == 0) ? $urandom : 0);
      gie        = ($urandom % 4) != 0;
      reg_addr   = 1'($urandom);
      reg_wr     = ($urandom % 4) == 0;
      reg_wdata  = 8'($urandom);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule